// File: doc/BRIEF.md
# Asymmetric Blink Pulse Generator

This block produces a square wave whose high and low times are set independently, each as a number of clock cycles. Raising the enable input starts the wave straight away with a high phase. While enable stays high, the output flips each time the phase timer has run for the length of the current phase. The timer then starts again from zero with the length that belongs to the new phase. Dropping enable stops the wave and forces the output low.

Two status outputs come with the wave. The elapsed-time output shows where the phase timer is within the current phase. The pulse-count output is a wrapping up-counter that advances once for every low-to-high change of the wave. The durations are read only when a phase begins, so software or logic can change them at any time without cutting short the phase already running.

Top module: `blink_gen`

## Requirements
- R1: A synchronous active-high reset clears the output level, the phase timer, the enable history and the pulse count, so out_o, elapsed_o and pcount_o all read 0 after it.
- R2: On the first clock edge that samples en_i high after it was low (or after reset), out_o goes high and elapsed_o reads 0, starting a high phase.
- R3: While enabled, each high phase lasts exactly on_dur_i cycles and each low phase exactly off_dur_i cycles, with no idle cycle between phases.
- R4: While enabled, elapsed_o counts 0, 1, 2, ... through the phase and returns to 0 in the cycle the output changes level.
- R5: A duration value of 0 is treated as 1, so every phase lasts at least one cycle; with both durations 0 the output alternates every cycle.
- R6: The on duration is captured when a high phase starts and the off duration when a low phase starts; a change during a phase only affects the next phase of that kind.
- R7: While en_i is low, out_o is 0 and elapsed_o is 0 in the same cycle, without waiting for a clock edge.
- R8: pcount_o (16 bits) increases by one in the cycle out_o rises, wraps from 65535 to 0, and holds its value while en_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; a rising edge starts a high phase |
| on_dur_i | input | 16 | High phase length in cycles (0 means 1) |
| off_dur_i | input | 16 | Low phase length in cycles (0 means 1) |
| out_o | output | 1 | Generated square wave |
| elapsed_o | output | 16 | Cycles elapsed in the current phase |
| pcount_o | output | 16 | Number of rising edges of out_o, wrapping |

## Verification
The assertions assume en_i and the duration inputs are stable around each rising clock edge and change only between edges. The timer-step and timer-restart properties also assume enable has been held high for two sampled edges before they apply, so they never claim anything about the starting cycle. The stimulus changes inputs only after the falling edge. It holds enable for whole runs, and it changes durations inside a running phase only in the mid-phase test.

// File: rtl/blink_pkg.sv
package blink_pkg;

    localparam int DUR_W_DEF = 16;
    localparam int CNT_W_DEF = 16;

    // Operating mode decoded once per cycle from enable and its history
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_START = 2'd1,
        MODE_RUN   = 2'd2
    } mode_t;

endpackage

// File: rtl/blink_edge.sv
module blink_edge
    import blink_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    output mode_t mode_o
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_i;
    end

    always_comb begin
        if (!en_i)     mode_o = MODE_OFF;
        else if (!en_q) mode_o = MODE_START;
        else           mode_o = MODE_RUN;
    end
endmodule

// File: rtl/blink_phase.sv
module blink_phase
    import blink_pkg::*;
#(
    parameter int DUR_W = DUR_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_t            mode_i,
    input  logic [DUR_W-1:0] on_dur_i,
    input  logic [DUR_W-1:0] off_dur_i,
    output logic             lvl_o,
    output logic [DUR_W-1:0] tmr_o,
    output logic             rise_o
);
    localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

    logic             lvl_q, lvl_d;
    logic [DUR_W-1:0] tmr_q, tmr_d;
    logic [DUR_W-1:0] lim_q, lim_d;
    logic [DUR_W-1:0] on_eff, off_eff;
    logic             last_cyc;

    assign on_eff   = (on_dur_i  == '0) ? ONE : on_dur_i;
    assign off_eff  = (off_dur_i == '0) ? ONE : off_dur_i;
    assign last_cyc = (tmr_q == lim_q - ONE);

    always_comb begin
        lvl_d = lvl_q;
        tmr_d = tmr_q;
        lim_d = lim_q;
        case (mode_i)
            MODE_OFF: begin
                lvl_d = 1'b0;
                tmr_d = '0;
            end
            MODE_START: begin
                lvl_d = 1'b1;
                tmr_d = '0;
                lim_d = on_eff;
            end
            default: begin
                if (last_cyc) begin
                    lvl_d = ~lvl_q;
                    tmr_d = '0;
                    lim_d = lvl_q ? off_eff : on_eff;
                end else begin
                    tmr_d = tmr_q + ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            tmr_q <= '0;
            lim_q <= ONE;
        end else begin
            lvl_q <= lvl_d;
            tmr_q <= tmr_d;
            lim_q <= lim_d;
        end
    end

    assign lvl_o  = lvl_q;
    assign tmr_o  = tmr_q;
    assign rise_o = lvl_d & ~lvl_q;
endmodule

// File: rtl/blink_pcount.sv
module blink_pcount #(
    parameter int CNT_W = blink_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst)        cnt_o <= '0;
        else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
    end
endmodule

// File: rtl/blink_gen.sv
module blink_gen
    import blink_pkg::*;
#(
    parameter int DUR_W = DUR_W_DEF,
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [DUR_W-1:0] on_dur_i,
    input  logic [DUR_W-1:0] off_dur_i,
    output logic             out_o,
    output logic [DUR_W-1:0] elapsed_o,
    output logic [CNT_W-1:0] pcount_o
);
    mode_t            mode;
    logic             lvl_q;
    logic [DUR_W-1:0] tmr;
    logic             rise;

    blink_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_i),
        .mode_o (mode)
    );

    blink_phase #(.DUR_W(DUR_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .on_dur_i  (on_dur_i),
        .off_dur_i (off_dur_i),
        .lvl_o     (lvl_q),
        .tmr_o     (tmr),
        .rise_o    (rise)
    );

    blink_pcount #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc_i (rise),
        .cnt_o (pcount_o)
    );

    assign out_o     = en_i & lvl_q;
    assign elapsed_o = en_i ? tmr : '0;
endmodule

// File: rtl/blink_gen_chk.sv
module blink_gen_chk #(
    parameter int DUR_W = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic             out_o,
    input logic [DUR_W-1:0] elapsed_o,
    input logic [CNT_W-1:0] pcount_o,
    input logic             lvl_q
);
    // R2
    start_high_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && !$past(en_i) && !$past(rst)) |=> (out_o || !en_i));

    // R4
    timer_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && $past(en_i) && $past(en_i, 2) && !$past(rst) && $stable(out_o))
        |-> (elapsed_o == $past(elapsed_o) + DUR_W'(1)));

    // R4
    timer_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && $past(en_i) && $past(en_i, 2) && !$past(rst) && !$stable(out_o))
        |-> (elapsed_o == '0));

    // R7
    off_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(en_i) && !$past(rst)) |-> !lvl_q);

    // R8
    pulse_count_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pcount_o == $past(pcount_o) + CNT_W'(lvl_q && !$past(lvl_q))));
endmodule

bind blink_gen blink_gen_chk #(.DUR_W(DUR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .out_o     (out_o),
    .elapsed_o (elapsed_o),
    .pcount_o  (pcount_o),
    .lvl_q     (lvl_q)
);

// File: tb/blink_gen_test.sv
`timescale 1ns/1ps
module blink_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0;
    logic [15:0] on_dur_i = 16'd0;
    logic [15:0] off_dur_i = 16'd0;
    logic        out_o;
    logic [15:0] elapsed_o;
    logic [15:0] pcount_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    int m_enq = 0, m_out = 0, m_tmr = 0, m_lim = 1, m_cnt = 0;

    always #4 clk = ~clk;

    blink_gen uut (
        .clk(clk), .rst(rst), .en_i(en_i),
        .on_dur_i(on_dur_i), .off_dur_i(off_dur_i),
        .out_o(out_o), .elapsed_o(elapsed_o), .pcount_o(pcount_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int eff(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_enq = 0; m_out = 0; m_tmr = 0; m_lim = 1; m_cnt = 0;
        end else if (!en_i) begin
            m_out = 0; m_tmr = 0; m_enq = 0;
        end else if (m_enq == 0) begin
            if (m_out == 0) m_cnt = (m_cnt + 1) % 65536;
            m_out = 1; m_tmr = 0; m_lim = eff(on_dur_i); m_enq = 1;
        end else if (m_tmr + 1 == m_lim) begin
            m_out = 1 - m_out;
            m_tmr = 0;
            m_lim = m_out ? eff(on_dur_i) : eff(off_dur_i);
            if (m_out == 1) m_cnt = (m_cnt + 1) % 65536;
        end else begin
            m_tmr = m_tmr + 1;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            if (!en_i) begin
                chk("R7 out", out_o, 0);
                chk("R7 elapsed", elapsed_o, 0);
            end else begin
                chk("R3 out", out_o, m_out);
                chk("R4 elapsed", elapsed_o, m_tmr);
            end
            chk("R8 count", pcount_o, m_cnt);
        end
    end

    task automatic step();
        @(negedge clk); #2;
    endtask

    initial begin
        int base;
        int pat_o[8];
        int pat_e[8];
        repeat (3) @(negedge clk);
        #2 rst = 1'b0;
        step();
        chk("R1 out", out_o, 0);
        chk("R1 elapsed", elapsed_o, 0);
        chk("R1 count", pcount_o, 0);

        // R2/R3/R4: on=3 off=2
        on_dur_i = 16'd3; off_dur_i = 16'd2; en_i = 1'b1;
        pat_o = '{1,1,1,0,0,1,1,1};
        pat_e = '{0,1,2,0,1,0,1,2};
        for (int i = 0; i < 8; i++) begin
            step();
            if (i == 0) begin
                chk("R2 out", out_o, 1);
                chk("R2 elapsed", elapsed_o, 0);
                chk("R2 count", pcount_o, 1);
            end
            chk("R3 pattern", out_o, pat_o[i]);
            chk("R4 pattern", elapsed_o, pat_e[i]);
        end

        // R7: drop enable, immediate effect, count holds
        base = pcount_o;
        en_i = 1'b0;
        #1;
        chk("R7 out now", out_o, 0);
        chk("R7 elapsed now", elapsed_o, 0);
        repeat (4) step();
        chk("R8 hold", pcount_o, base);

        // R5: zero durations alternate every cycle
        on_dur_i = 16'd0; off_dur_i = 16'd0; en_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R5 out", out_o, (i % 2 == 0) ? 1 : 0);
            chk("R5 elapsed", elapsed_o, 0);
        end
        en_i = 1'b0;
        repeat (2) step();

        // R6: change durations mid high phase
        on_dur_i = 16'd4; off_dur_i = 16'd4; en_i = 1'b1;
        pat_o = '{1,1,1,1,0,1,0,1};
        for (int i = 0; i < 8; i++) begin
            step();
            if (i == 0) begin
                on_dur_i = 16'd1; off_dur_i = 16'd1;
            end
            chk("R6 out", out_o, pat_o[i]);
        end
        en_i = 1'b0;
        repeat (2) step();

        // R8: 65536 pulses return the count to its start value
        base = pcount_o;
        on_dur_i = 16'd1; off_dur_i = 16'd1; en_i = 1'b1;
        repeat (131072) @(negedge clk);
        #2;
        chk("R8 wrap", pcount_o, base);
        en_i = 1'b0;
        repeat (2) step();

        // R1: reset mid-run
        en_i = 1'b1;
        repeat (3) step();
        rst = 1'b1;
        step();
        rst = 1'b0; en_i = 1'b0;
        step();
        chk("R1 count after reset", pcount_o, 0);
        chk("R1 out after reset", out_o, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule